// File: doc/BRIEF.md
# Wait-State Bus Cycle Sequencer

This block sits between a processor core and its external memory bus and runs one read or write transfer at a time. A transfer starts when the core raises a request while the sequencer is idle. The sequencer latches the address, direction, instruction-fetch flag and write data, and spends exactly one cycle in an address phase driving them onto the bus. It then enters a data phase that repeats for as long as the external ready line is low. In the cycle that ready is high, the sequencer accepts the data, signals completion to the core and returns to idle.

The program-counter increment does not get a cycle of its own. For instruction fetches, the sequencer pulses a program-counter increment strobe once, in the first data-phase cycle, so that the increment overlaps the wait for memory. The ready line is only looked at during the data phase. A ready level seen during the address phase does nothing.

Top module: `bus_seq`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, `bus_cyc`, `bus_rd`, `bus_oe`, `core_busy`, `core_done` and `pc_inc` are 0, and `bus_addr` and `core_rdata` are 0.
- R2: A request (`core_req` high) is accepted only when `core_busy` is 0. The address phase occupies the next cycle, with `bus_cyc` high, `bus_addr` equal to the requested address, and `bus_rd` equal to the inverse of `core_we`.
- R3: The address phase lasts exactly one cycle. `bus_rdy` high during it neither raises `core_done` nor ends the transfer.
- R4: In the data phase, each cycle with `bus_rdy` low is a wait cycle. The data phase repeats, with `core_done` low.
- R5: `core_done` is high for exactly one cycle, the data-phase cycle in which `bus_rdy` is high. On the following cycle `bus_cyc` and `core_busy` are 0.
- R6: For a read, `core_rdata` equals `bus_rdata` in the `core_done` cycle and keeps that value afterwards. A write leaves `core_rdata` unchanged.
- R7: For a transfer requested with `core_fetch` high, `pc_inc` is high for exactly one cycle, the first data-phase cycle, whatever the number of wait cycles. For any other transfer it stays 0.
- R8: `bus_addr`, `bus_rd`, `bus_oe` and `bus_wdata` stay constant from the address phase to the end of the transfer. Changes on the request inputs while busy have no effect.
- R9: For a write, `bus_oe` is high and `bus_wdata` equals the requested data in both phases. For a read, `bus_oe` is 0.
- R10: Reset asserted in the middle of a transfer returns the sequencer to idle on the next cycle, with all bus strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core requests a transfer |
| core_addr | input | AW | Transfer address |
| core_we | input | 1 | 1 = write, 0 = read |
| core_fetch | input | 1 | Transfer is an instruction fetch |
| core_wdata | input | DW | Write data |
| core_rdata | output | DW | Read data returned to the core |
| core_done | output | 1 | One-cycle completion pulse |
| core_busy | output | 1 | Transfer in progress |
| pc_inc | output | 1 | Program-counter increment strobe |
| bus_addr | output | AW | External address |
| bus_rd | output | 1 | Read strobe (R/W high = read) during a cycle |
| bus_oe | output | 1 | Write-data drive enable |
| bus_wdata | output | DW | External write data |
| bus_cyc | output | 1 | Bus transfer active |
| bus_rdata | input | DW | External read data |
| bus_rdy | input | 1 | External ready |

## Verification
The bench raises ready during the address phase. A sequencer that qualified ready too early would finish a cycle early and return wrong data. It runs fetches with zero and several wait states. A design that pulsed the increment strobe on every wait cycle, or skipped it on zero-wait fetches, would show a pulse count other than one. During waits it changes the request inputs and keeps the request line high, which exposes a sequencer that re-latches the address or accepts a new transfer while busy. It also asserts reset in the middle of a transfer, so a design that left its strobes up after reset would be caught.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;

  // next phase of the bus cycle
  function automatic phase_t next_phase(phase_t cur, logic start, logic rdy);
    case (cur)
      PH_IDLE: next_phase = start ? PH_ADDR : PH_IDLE;
      PH_ADDR: next_phase = PH_DATA;
      PH_DATA: next_phase = rdy ? PH_IDLE : PH_DATA;
      default: next_phase = PH_IDLE;
    endcase
  endfunction

  // data accepted: only in the data phase, with ready high
  function automatic logic data_accept(phase_t cur, logic rdy);
    data_accept = (cur == PH_DATA) && rdy;
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   rdy,
  input  logic   fetch,
  output phase_t phase,
  output logic   accept,
  output logic   pc_strobe
);
  logic waited_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      waited_q <= 1'b0;
    end else begin
      phase <= next_phase(phase, start, rdy);
      if (phase == PH_ADDR)
        waited_q <= 1'b0;
      else if (phase == PH_DATA)
        waited_q <= 1'b1;
    end
  end

  assign accept    = data_accept(phase, rdy);
  assign pc_strobe = (phase == PH_DATA) && !waited_q && fetch;
endmodule

// File: rtl/bus_seq_hold.sv
module bus_seq_hold #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic          we_in,
  input  logic          fetch_in,
  input  logic [DW-1:0] wdata_in,
  output logic [AW-1:0] addr_q,
  output logic          we_q,
  output logic          fetch_q,
  output logic [DW-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_in;
      we_q    <= we_in;
      fetch_q <= fetch_in;
      wdata_q <= wdata_in;
    end
  end
endmodule

// File: rtl/bus_seq_rcap.sv
module bus_seq_rcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)       held_q <= '0;
    else if (take) held_q <= din;
  end

  assign dout = take ? din : held_q;
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_req,
  input  logic [AW-1:0] core_addr,
  input  logic          core_we,
  input  logic          core_fetch,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  output logic          core_done,
  output logic          core_busy,
  output logic          pc_inc,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_oe,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_cyc,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy
);
  phase_t phase;
  logic   start, accept, we_q, fetch_q;
  logic   phase_addr, phase_data, read_take;

  assign start      = core_req && (phase == PH_IDLE);
  assign phase_addr = (phase == PH_ADDR);
  assign phase_data = (phase == PH_DATA);
  assign read_take  = accept && !we_q;

  bus_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .rdy(bus_rdy), .fetch(fetch_q),
    .phase(phase), .accept(accept), .pc_strobe(pc_inc)
  );

  bus_seq_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst(rst), .load(start),
    .addr_in(core_addr), .we_in(core_we), .fetch_in(core_fetch),
    .wdata_in(core_wdata),
    .addr_q(bus_addr), .we_q(we_q), .fetch_q(fetch_q), .wdata_q(bus_wdata)
  );

  bus_seq_rcap #(.DW(DW)) u_rcap (
    .clk(clk), .rst(rst), .take(read_take), .din(bus_rdata), .dout(core_rdata)
  );

  assign bus_cyc   = phase_addr || phase_data;
  assign bus_rd    = bus_cyc && !we_q;
  assign bus_oe    = bus_cyc && we_q;
  assign core_busy = bus_cyc;
  assign core_done = accept;
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          phase_addr,
  input logic          phase_data,
  input logic          core_done,
  input logic          pc_inc,
  input logic          bus_rdy,
  input logic          bus_cyc,
  input logic          bus_rd,
  input logic          bus_oe,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata
);
  // R3
  addr_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    phase_addr |=> phase_data);
  // R3
  no_done_in_addr_chk: assert property (@(posedge clk) disable iff (rst)
    phase_addr |-> !core_done);
  // R4
  wait_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_data && !bus_rdy) |=> phase_data);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    core_done |=> (!core_done && !bus_cyc));
  // R5
  done_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    core_done |-> (phase_data && bus_rdy));
  // R7
  pc_single_chk: assert property (@(posedge clk) disable iff (rst)
    pc_inc |=> !pc_inc);
  // R7
  pc_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> phase_data);
  // R8
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    phase_data |-> ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_oe) && $stable(bus_wdata)));
  // R9
  dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_oe));
endmodule

bind bus_seq bus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .phase_addr(phase_addr), .phase_data(phase_data),
  .core_done(core_done), .pc_inc(pc_inc), .bus_rdy(bus_rdy), .bus_cyc(bus_cyc),
  .bus_rd(bus_rd), .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/bus_seq_test.sv
module bus_seq_test;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef struct packed {
    logic [15:0] addr;
    logic        we;
    logic        fetch;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [3:0]  waits;
    logic        rdy_early;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{16'h1234, 1'b0, 1'b1, 8'h00, 8'hA5, 4'd0, 1'b0},
    '{16'h2000, 1'b0, 1'b1, 8'h00, 8'h3C, 4'd3, 1'b1},
    '{16'h8001, 1'b1, 1'b0, 8'h77, 8'h11, 4'd2, 1'b1},
    '{16'h00FF, 1'b0, 1'b0, 8'h00, 8'h5A, 4'd1, 1'b0},
    '{16'hFFFE, 1'b1, 1'b0, 8'hC3, 8'h99, 4'd0, 1'b1},
    '{16'h4321, 1'b0, 1'b1, 8'h00, 8'hE7, 4'd5, 1'b0}
  };

  logic clk = 0, rst = 1;
  logic core_req = 0, core_we = 0, core_fetch = 0, bus_rdy = 0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0, bus_rdata = '0;
  logic [DW-1:0] core_rdata, bus_wdata;
  logic core_done, core_busy, pc_inc, bus_rd, bus_oe, bus_cyc;
  logic [AW-1:0] bus_addr;

  int checks = 0, failures = 0;
  logic [DW-1:0] last_read = '0;

  bus_seq #(.AW(AW), .DW(DW)) uut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input vec_t v);
    int pcs = 0;
    @(negedge clk);
    core_req = 1; core_addr = v.addr; core_we = v.we; core_fetch = v.fetch;
    core_wdata = v.wdata; bus_rdy = 0;
    // address phase
    @(negedge clk);
    core_addr = ~v.addr; core_wdata = ~v.wdata; core_we = ~v.we; core_fetch = ~v.fetch;
    bus_rdy = v.rdy_early; bus_rdata = ~v.rdata;
    #1;
    check(bus_cyc && core_busy, "R2", {bus_cyc, core_busy}, 2'b11);
    check(bus_addr == v.addr, "R2", bus_addr, v.addr);
    check(bus_rd == !v.we, "R2", bus_rd, !v.we);
    check(!core_done, "R3", core_done, 0);
    check(bus_oe == v.we, "R9", bus_oe, v.we);
    if (v.we) check(bus_wdata == v.wdata, "R9", bus_wdata, v.wdata);
    pcs += pc_inc;
    // data phase
    for (int k = 0; k <= int'(v.waits); k++) begin
      @(negedge clk);
      bus_rdy = (k == int'(v.waits));
      core_req = (k != int'(v.waits));
      bus_rdata = bus_rdy ? v.rdata : ~v.rdata;
      #1;
      if (k == 0) check(pc_inc == v.fetch, "R7", pc_inc, v.fetch);
      pcs += pc_inc;
      check(core_done == bus_rdy, bus_rdy ? "R5" : "R4", core_done, bus_rdy);
      check(bus_addr == v.addr && bus_rd == !v.we && bus_oe == v.we, "R8", bus_addr, v.addr);
      if (v.we) check(bus_wdata == v.wdata, "R8", bus_wdata, v.wdata);
      if (bus_rdy && !v.we) begin
        check(core_rdata == v.rdata, "R6", core_rdata, v.rdata);
        last_read = v.rdata;
      end
    end
    @(negedge clk);
    bus_rdy = 0; bus_rdata = 8'h00;
    #1;
    check(!bus_cyc && !core_busy && !core_done, "R5", {bus_cyc, core_busy, core_done}, 0);
    check(pcs == int'(v.fetch), "R7", pcs, v.fetch);
    check(core_rdata == last_read, "R6", core_rdata, last_read);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check(!bus_cyc && !bus_rd && !bus_oe && !core_busy && !core_done && !pc_inc, "R1",
          {bus_cyc, bus_rd, bus_oe, core_busy, core_done, pc_inc}, 0);
    check(bus_addr == 0 && core_rdata == 0, "R1", bus_addr, 0);
    @(negedge clk); rst = 0;
    #1;
    check(!bus_cyc && !core_busy, "R1", bus_cyc, 0);

    for (int i = 0; i < NV; i++) run_txn(VEC[i]);

    // R10: reset in the middle of a wait
    @(negedge clk);
    core_req = 1; core_addr = 16'h5555; core_we = 0; core_fetch = 1;
    @(negedge clk); core_req = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    #1;
    check(!bus_cyc && !bus_rd && !bus_oe && !core_busy && !pc_inc, "R10",
          {bus_cyc, bus_rd, bus_oe, core_busy, pc_inc}, 0);
    last_read = '0;
    check(core_rdata == 0, "R10", core_rdata, 0);
    run_txn(VEC[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule